// File: doc/BRIEF.md
# Soft-Start and Power-Good Sequencer

This block is the digital start-up controller of a single-phase buck regulator. It watches two supply-OK flags and an enable input. While any of the three is low it holds the regulator idle. Once all three are high it waits a fixed number of switching clocks. It then raises a digital reference code by one step per switching clock, from zero to full scale. An external DAC turns that code into the regulation target.

During the ramp the sequencer keeps undervoltage checking off until the reference has passed 80 percent of full scale. An undervoltage seen after that point, while the ramp is still running, does not latch a fault. Instead the reference drops to zero, the block waits a separate fixed number of clocks, and the ramp starts again from zero. When the ramp tops out, a soft-start-done flag rises. Power-good follows three clocks later, and only while the sense-window comparators report a healthy output. The overvoltage comparator is never gated by the sequencer. Its flag only takes power-good away.

Top module: `softstart_seq`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `ref_code` is 0 and `uv_arm`, `ss_done` and `pgood` are all low.
- R2: The sequencer leaves idle only when `supply_a_ok`, `supply_b_ok` and `enable` are all high. With any one of them low, `ref_code` stays 0 and `ss_done` stays low for any length of time.
- R3: The first clock edge that samples all three start inputs high moves the block into a start delay of `INIT_DLY` clocks (default 64). The ramp then spends one clock at code 0. `ref_code` first becomes 1 on the (`INIT_DLY`+2)-th rising edge that samples the start inputs high.
- R4: During the ramp `ref_code` rises by exactly 1 per clock. After code 1 it takes 1023 more edges until `ss_done` goes high, with `ref_code` at full scale (all ones, 1023). It stays there while the start inputs remain high.
- R5: `uv_arm` is high exactly when the sequencer is ramping or done and `ref_code` is at least the arm code, which is floor(2^`REF_W` × `ARM_PCT` / 100). The default arm code is 819.
- R6: A high `sense_uv` sampled while `uv_arm` is high during the ramp sets `ref_code` to 0 on that edge. `ss_done` stays low. After `RESTART_DLY` clocks (default 64) the ramp restarts from 0, so `ref_code` is 1 on the (`RESTART_DLY`+1)-th edge after the restart edge.
- R7: A high `sense_uv` while `uv_arm` is low has no effect: the ramp keeps stepping by one per clock.
- R8: `pgood` is low during the delays and the ramp. It can first go high on the third rising edge after the one that raised `ss_done`.
- R9: Once `ss_done` has been high for three edges, `pgood` equals `sense_in_win` AND NOT `sense_ov` AND NOT `sense_uv`. These flags act on `pgood` without waiting for a clock. An undervoltage at this stage clears neither `ss_done` nor the reference.
- R10: A clock edge that samples `enable`, `supply_a_ok` or `supply_b_ok` low returns the sequencer to idle. After that edge `ref_code` is 0 and `ss_done`, `uv_arm` and `pgood` are low. A later start begins again with the full start delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching clock; all counting is in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| supply_a_ok | input | 1 | First supply above its lockout threshold |
| supply_b_ok | input | 1 | Second supply above its lockout threshold |
| enable | input | 1 | Converter enable, high to run |
| sense_in_win | input | 1 | Sensed output within ±10 % of the reference |
| sense_ov | input | 1 | Overvoltage comparator flag |
| sense_uv | input | 1 | Undervoltage comparator flag |
| ref_code | output | REF_W (10) | Digital reference code for the DAC |
| uv_arm | output | 1 | Undervoltage monitoring armed |
| ss_done | output | 1 | Soft-start ramp complete |
| pgood | output | 1 | Active-high power-good |

## Verification
The hardest situation to reach is an undervoltage that lands in the narrow band between the arm code and full scale while the ramp is still running. Reaching it requires a complete start delay and more than 800 ramp steps first. The stimulus waits on the observed reference code and pulses `sense_uv` at code 900. It then confirms the drop to zero, the restart delay and a second full ramp. A pulse at code 400 shows that the same flag is ignored below the arm code. The drop of a supply flag in mid-ramp is approached the same way, by waiting on the code.

// File: rtl/ss_pkg.sv
package ss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_RAMP,
        ST_BACK,
        ST_RUN
    } ss_state_e;

    typedef struct packed {
        logic in_win;
        logic ov;
        logic uv;
    } sense_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int arm_code(input int width, input int pct);
        return ((1 << width) * pct) / 100;
    endfunction

    function automatic int cnt_width(input int limit);
        return (limit < 2) ? 1 : $clog2(limit);
    endfunction

endpackage

// File: rtl/ss_delay.sv
module ss_delay #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] last,
    output logic          expired
);
    logic [CW-1:0] cnt;

    assign expired = run && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || !run || expired) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ss_ramp.sv
module ss_ramp #(
    parameter int REF_W = 10,
    parameter int ARM   = 819
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [REF_W-1:0] ref_code,
    output logic             at_top,
    output logic             past_arm
);
    localparam logic [REF_W-1:0] ARM_V = REF_W'(ARM);

    assign at_top   = &ref_code;
    assign past_arm = (ref_code >= ARM_V);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ref_code <= '0;
        end else if (inc) begin
            ref_code <= ref_code + 1'b1;
        end
    end
endmodule

// File: rtl/ss_pg.sv
module ss_pg
    import ss_pkg::*;
#(
    parameter int PG_DLY = 3
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   in_run,
    input  sense_t sense,
    output logic   pgood
);
    localparam int PW = $clog2(PG_DLY + 1);
    localparam logic [PW-1:0] PG_LAST = PW'(PG_DLY);

    logic [PW-1:0] pg_cnt;
    logic          aged;

    assign aged  = in_run && (pg_cnt == PG_LAST);
    assign pgood = aged && sense.in_win && !sense.ov && !sense.uv;

    always_ff @(posedge clk) begin
        if (rst || !in_run) begin
            pg_cnt <= '0;
        end else if (pg_cnt != PG_LAST) begin
            pg_cnt <= pg_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
    import ss_pkg::*;
#(
    parameter int REF_W       = 10,
    parameter int INIT_DLY    = 64,
    parameter int RESTART_DLY = 64,
    parameter int PG_DLY      = 3,
    parameter int ARM_PCT     = 80
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             supply_a_ok,
    input  logic             supply_b_ok,
    input  logic             enable,
    input  logic             sense_in_win,
    input  logic             sense_ov,
    input  logic             sense_uv,
    output logic [REF_W-1:0] ref_code,
    output logic             uv_arm,
    output logic             ss_done,
    output logic             pgood
);
    localparam int DCW = cnt_width(max2(INIT_DLY, RESTART_DLY));
    localparam int ARM = arm_code(REF_W, ARM_PCT);
    localparam logic [DCW-1:0] INIT_LAST = DCW'(INIT_DLY - 1);
    localparam logic [DCW-1:0] BACK_LAST = DCW'(RESTART_DLY - 1);

    ss_state_e      st, nxt;
    logic           go;
    logic           restart;
    logic           dly_run;
    logic [DCW-1:0] dly_last;
    logic           dly_expired;
    logic           ramp_clr;
    logic           ramp_inc;
    logic           at_top;
    logic           past_arm;
    sense_t         sense;

    assign go      = supply_a_ok && supply_b_ok && enable;
    assign restart = (st == ST_RAMP) && sense_uv && past_arm;
    assign sense   = '{in_win: sense_in_win, ov: sense_ov, uv: sense_uv};

    always_comb begin
        nxt = st;
        if (!go) begin
            nxt = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: nxt = ST_WAIT;
                ST_WAIT: if (dly_expired) nxt = ST_RAMP;
                ST_RAMP: begin
                    if (restart)     nxt = ST_BACK;
                    else if (at_top) nxt = ST_RUN;
                end
                ST_BACK: if (dly_expired) nxt = ST_RAMP;
                ST_RUN:  nxt = ST_RUN;
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            st <= nxt;
        end
    end

    assign dly_run  = go && ((st == ST_WAIT) || (st == ST_BACK));
    assign dly_last = (st == ST_WAIT) ? INIT_LAST : BACK_LAST;

    ss_delay #(.CW(DCW)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .run     (dly_run),
        .last    (dly_last),
        .expired (dly_expired)
    );

    assign ramp_clr = !go || restart || ((st != ST_RAMP) && (st != ST_RUN));
    assign ramp_inc = go && (st == ST_RAMP) && !at_top && !restart;

    ss_ramp #(.REF_W(REF_W), .ARM(ARM)) u_ramp (
        .clk      (clk),
        .rst      (rst),
        .clr      (ramp_clr),
        .inc      (ramp_inc),
        .ref_code (ref_code),
        .at_top   (at_top),
        .past_arm (past_arm)
    );

    assign uv_arm  = past_arm && ((st == ST_RAMP) || (st == ST_RUN));
    assign ss_done = (st == ST_RUN);

    ss_pg #(.PG_DLY(PG_DLY)) u_pg (
        .clk    (clk),
        .rst    (rst),
        .in_run (ss_done),
        .sense  (sense),
        .pgood  (pgood)
    );
endmodule

// File: rtl/ss_seq_chk.sv
module ss_seq_chk #(
    parameter int REF_W   = 10,
    parameter int ARM_PCT = 80
) (
    input logic             clk,
    input logic             rst,
    input logic             supply_a_ok,
    input logic             supply_b_ok,
    input logic             enable,
    input logic             sense_in_win,
    input logic             sense_ov,
    input logic             sense_uv,
    input logic [REF_W-1:0] ref_code,
    input logic             uv_arm,
    input logic             ss_done,
    input logic             pgood
);
    localparam logic [REF_W-1:0] ARM_V = REF_W'(((1 << REF_W) * ARM_PCT) / 100);

    logic go;
    assign go = supply_a_ok && supply_b_ok && enable;

    p_ramp_step_r4: assert property (@(posedge clk) disable iff (rst)
        (go && !ss_done && (ref_code != '0) && !sense_uv)
        |=> (ss_done || (ref_code == $past(ref_code) + 1'b1)));

    p_done_full_r4: assert property (@(posedge clk) disable iff (rst)
        ss_done |-> (&ref_code));

    p_arm_code_r5: assert property (@(posedge clk) disable iff (rst)
        uv_arm |-> (ref_code >= ARM_V));

    p_uv_restart_r6: assert property (@(posedge clk) disable iff (rst)
        (go && uv_arm && sense_uv && !ss_done) |=> ((ref_code == '0) && !ss_done));

    p_pg_after_done_r8: assert property (@(posedge clk) disable iff (rst)
        pgood |-> (ss_done && $past(ss_done)));

    p_pg_window_r9: assert property (@(posedge clk) disable iff (rst)
        pgood |-> (sense_in_win && !sense_ov && !sense_uv));

    p_drop_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !go |=> ((ref_code == '0) && !ss_done && !pgood && !uv_arm));
endmodule

bind softstart_seq ss_seq_chk #(.REF_W(REF_W), .ARM_PCT(ARM_PCT)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .supply_a_ok  (supply_a_ok),
    .supply_b_ok  (supply_b_ok),
    .enable       (enable),
    .sense_in_win (sense_in_win),
    .sense_ov     (sense_ov),
    .sense_uv     (sense_uv),
    .ref_code     (ref_code),
    .uv_arm       (uv_arm),
    .ss_done      (ss_done),
    .pgood        (pgood)
);

// File: tb/softstart_seq_bench.sv
`timescale 1ns/1ps
module softstart_seq_bench;
    localparam int REF_W    = 10;
    localparam int INIT_DLY = 64;
    localparam int BACK_DLY = 64;
    localparam int PG_DLY   = 3;
    localparam int ARM      = 819;
    localparam int TOP      = 1023;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sa = 1'b0, sb = 1'b0, en = 1'b0;
    logic win = 1'b1, ov = 1'b0, uv = 1'b0;
    logic [REF_W-1:0] ref_code;
    logic uv_arm, ss_done, pgood;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    string cur = "R1";

    always #4 clk = ~clk;

    softstart_seq u_softstart_seq (
        .clk(clk), .rst(rst),
        .supply_a_ok(sa), .supply_b_ok(sb), .enable(en),
        .sense_in_win(win), .sense_ov(ov), .sense_uv(uv),
        .ref_code(ref_code), .uv_arm(uv_arm), .ss_done(ss_done), .pgood(pgood)
    );

    // behavioural reference: 0 idle, 1 start delay, 2 ramp, 3 restart delay, 4 done
    int m_ph = 0, m_cnt = 0, m_ref = 0, m_age = 0;

    always @(posedge clk) begin
        if (rst || !(sa && sb && en)) begin
            m_ph = 0; m_cnt = 0; m_ref = 0; m_age = 0;
        end else begin
            case (m_ph)
                0: begin m_ph = 1; m_cnt = 0; end
                1: if (m_cnt == INIT_DLY - 1) begin m_ph = 2; m_ref = 0; end
                   else m_cnt++;
                2: if (uv && m_ref >= ARM) begin m_ph = 3; m_cnt = 0; m_ref = 0; end
                   else if (m_ref == TOP) begin m_ph = 4; m_age = 0; end
                   else m_ref++;
                3: if (m_cnt == BACK_DLY - 1) m_ph = 2;
                   else m_cnt++;
                default: if (m_age < PG_DLY) m_age++;
            endcase
        end
    end

    always @(negedge clk) begin
        if (!rst && !finished) begin
            automatic int e_arm  = (m_ref >= ARM && (m_ph == 2 || m_ph == 4)) ? 1 : 0;
            automatic int e_done = (m_ph == 4) ? 1 : 0;
            automatic int e_pg   = (m_ph == 4 && m_age == PG_DLY && win && !ov && !uv) ? 1 : 0;
            checks++;
            if (int'(ref_code) != m_ref || int'(uv_arm) != e_arm ||
                int'(ss_done) != e_done || int'(pgood) != e_pg) begin
                errors++;
                $display("FAIL %s model: ref/arm/done/pg actual %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
                         cur, ref_code, uv_arm, ss_done, pgood, m_ref, e_arm, e_done, e_pg);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wait_ref(input int v);
        int g = 0;
        while (int'(ref_code) != v && g < 5000) begin step(1); g++; end
    endtask

    task automatic wait_done();
        int g = 0;
        while (!ss_done && g < 5000) begin step(1); g++; end
    endtask

    initial begin
        int n;
        step(4);
        #1;
        chk("R1 ref in reset", int'(ref_code), 0);
        chk("R1 flags in reset", int'({uv_arm, ss_done, pgood}), 0);
        rst = 1'b0;
        step(1);
        chk("R1 ref after reset", int'(ref_code), 0);

        cur = "R2";
        sa = 1; sb = 0; en = 1; step(100);
        chk("R2 supply b low", int'(ref_code) + int'(ss_done), 0);
        sa = 0; sb = 1; step(100);
        chk("R2 supply a low", int'(ref_code) + int'(ss_done), 0);
        sa = 1; en = 0; step(100);
        chk("R2 enable low", int'(ref_code) + int'(ss_done), 0);

        cur = "R3";
        en = 1;
        n = 0;
        while (int'(ref_code) != 1 && n < 500) begin step(1); n++; end
        chk("R3 edges to first step", n, INIT_DLY + 2);

        cur = "R7";
        wait_ref(400);
        uv = 1; step(3); uv = 0; step(1);
        chk("R7 uv ignored below arm", int'(ref_code), 404);

        cur = "R5";
        wait_ref(ARM - 1);
        chk("R5 not armed below code", int'(uv_arm), 0);
        step(1);
        chk("R5 armed at code", int'(uv_arm), 1);

        cur = "R6";
        wait_ref(900);
        uv = 1; step(1); uv = 0;
        chk("R6 ref cleared", int'(ref_code), 0);
        chk("R6 done low", int'(ss_done), 0);
        n = 0;
        while (int'(ref_code) != 1 && n < 500) begin step(1); n++; end
        chk("R6 edges to restart", n, BACK_DLY + 1);

        cur = "R4";
        n = 0;
        while (!ss_done && n < 5000) begin step(1); n++; end
        chk("R4 edges code1 to done", n, TOP);
        chk("R4 full scale", int'(ref_code), TOP);
        chk("R8 pgood low at done", int'(pgood), 0);

        cur = "R8";
        n = 0;
        while (!pgood && n < 50) begin step(1); n++; end
        chk("R8 pgood delay", n, PG_DLY);

        cur = "R9";
        win = 0; #1; chk("R9 out of window", int'(pgood), 0);
        win = 1; #1; chk("R9 window back", int'(pgood), 1);
        ov = 1;  #1; chk("R9 overvoltage", int'(pgood), 0);
        ov = 0; uv = 1; #1; chk("R9 undervoltage", int'(pgood), 0);
        step(5);
        chk("R9 done kept under uv", int'(ss_done), 1);
        uv = 0; #1; chk("R9 uv cleared", int'(pgood), 1);

        cur = "R10";
        step(1);
        en = 0; step(1);
        chk("R10 enable drop", int'({ss_done, pgood, uv_arm}) + int'(ref_code), 0);
        en = 1;
        wait_ref(500);
        sb = 0; step(1);
        chk("R10 supply drop ref", int'(ref_code), 0);
        sb = 1;
        n = 0;
        while (int'(ref_code) != 1 && n < 500) begin step(1); n++; end
        chk("R10 full delay again", n, INIT_DLY + 2);
        wait_done();
        step(PG_DLY + 2);
        chk("R10 pgood after restart", int'(pgood), 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog %s: actual timeout expected completion", cur);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule